// File: doc/BRIEF.md
# S/PDIF Stereo Frame Transmitter

This block turns a stream of stereo PCM pairs into a one-wire S/PDIF signal with biphase-mark line coding. Each stereo frame carries two 32-slot subframes, left first and then right. A subframe opens with a synchronising preamble. A 24-slot audio field follows, and then four flag slots: validity, user data, channel status and parity. Frames are counted in blocks of 192, and the first left subframe of every block carries the block-start preamble. The channel-status slot of frame i carries bit i of a 192-bit status word.

No audio clock is needed. A programmable divider on the system bus clock makes the half-slot tick, and one stereo frame takes 128 ticks. Firmware sets the division so that the frame rate comes close to the sample rate it wants (32, 44.1 or 48 kHz, with 48 kHz the usual setting). Samples arrive over a ready/valid pair. The block holds one pending pair and asks for the next once the frame boundary has consumed it. If nothing is pending at a frame boundary, the previous audio is sent again with the validity flag raised.

Top module: `spdif_tx`

## Requirements
- R1: Half-slot ticks occur every `div_ratio`+1 clocks. The first tick comes `div_ratio`+1 clocks after reset is released. The line changes only in the clock after a tick.
- R2: In slots 4 to 31 the line toggles at the start of every slot, and toggles again mid-slot exactly when the slot's bit is 1.
- R3: Preambles span slots 0 to 3 (8 half-slots). Written from first to last half-slot and taken relative to a prior line level of 0, they are: block start (left subframe of frame 0) 11101000, other left subframes 11100010, right subframes 11100100. When the prior level is 1, all eight values are inverted.
- R4: Slots 4 to 27 carry the 24-bit audio field, least significant bit first. Slot 28 is validity, slot 29 is the user bit (always 0), slot 30 is channel status, and slot 31 is parity chosen so that slots 4 to 31 hold an even number of ones.
- R5: With `fmt24`=0 the audio field is `{sample[15:0], 8'h00}`. With `fmt24`=1 it is `sample[23:0]`. The format is sampled when a pair is loaded at a frame boundary.
- R6: The channel-status slot of both subframes of frame i (0 to 191 within the block) equals `chan_stat[i]`.
- R7: The frame index wraps from 191 to 0, so a block-start preamble follows every 192 frames.
- R8: `smp_ready` is high while the pending holder is empty. A pair is accepted on a clock where `smp_valid` and `smp_ready` are both high. `smp_ready` then stays low until the next frame boundary moves the pair into transmission, so at most one pair is taken per frame.
- R9: A pair accepted during frame n is sent in frame n+1 with validity 0. If no pair is pending at a frame boundary, the previous audio fields are repeated with validity 1. After reset the fields are zero and validity is 1 until the first pair is loaded.
- R10: During reset `spdif_out` is 0 and `smp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_ratio | input | DIV_W | Half-slot tick period minus one, in clocks |
| fmt24 | input | 1 | 1 = 24-bit samples, 0 = 16-bit samples |
| chan_stat | input | FRAMES | Channel-status word, bit i sent in frame i |
| smp_valid | input | 1 | A stereo pair is offered |
| smp_ready | output | 1 | The pending holder can take a pair |
| smp_left | input | 24 | Left sample (bits 15:0 used in 16-bit mode) |
| smp_right | input | 24 | Right sample (bits 15:0 used in 16-bit mode) |
| spdif_out | output | 1 | Biphase-mark coded serial line |

## Verification
Each half-slot reaches the line one clock after its tick. The first tick falls `div_ratio`+1 clocks after reset, so the bench waits for the first rising edge of the line, checks that delay, and then samples once per tick period, half a clock after the edge that updates the line. In between it confirms the line holds still. A pair offered just after a frame starts has `smp_ready` low one clock later and must appear in the following frame. The bench therefore offers pairs only at the start of a frame, and predicts the next frame's fields, validity and status bit from what it offered.

// File: rtl/spdif_pkg.sv
package spdif_pkg;

  typedef enum logic [1:0] {PRE_BLOCK, PRE_LEFT, PRE_RIGHT} pre_kind_t;

  // Half-slot pattern of a preamble, MSB first, for a prior line level of 0.
  function automatic logic [7:0] pre_pattern(input pre_kind_t kind);
    case (kind)
      PRE_BLOCK: return 8'b1110_1000;
      PRE_LEFT:  return 8'b1110_0010;
      default:   return 8'b1110_0100;
    endcase
  endfunction

  // Audio field placement: 16-bit samples sit at the MSB end.
  function automatic logic [23:0] fmt_field(input logic [23:0] raw, input logic wide);
    return wide ? raw : {raw[15:0], 8'h00};
  endfunction

  // Bit carried by a given slot of a subframe (slots 0..3 are the preamble).
  function automatic logic slot_bit(input logic [23:0] field, input logic vld,
                                    input logic cst, input logic [4:0] slot);
    logic [4:0] idx;
    idx = slot - 5'd4;
    if (slot < 5'd4)   return 1'b0;
    if (slot == 5'd28) return vld;
    if (slot == 5'd29) return 1'b0;
    if (slot == 5'd30) return cst;
    if (slot == 5'd31) return ^{field, vld, cst};
    return field[idx];
  endfunction

endpackage

// File: rtl/spdif_tick_div.sv
module spdif_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt == div_ratio);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spdif_framer.sv
module spdif_framer
  import spdif_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FRM_W = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fmt24,
  input  logic             smp_valid,
  input  logic [23:0]      smp_left,
  input  logic [23:0]      smp_right,
  output logic             smp_ready,
  output logic [5:0]       hcnt,
  output logic             sub,
  output logic [FRM_W-1:0] frm,
  output logic [23:0]      field,
  output logic             vbit,
  output logic             frame_end
);
  logic        pend_full;
  logic [23:0] pend_l, pend_r;
  logic [23:0] cur_l, cur_r;
  logic        accept;

  assign smp_ready = !pend_full;
  assign accept    = smp_valid && smp_ready;
  assign frame_end = tick && (hcnt == 6'd63) && sub;
  assign field     = sub ? cur_r : cur_l;

  // Position counters: half-slot, subframe, frame within block.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      sub  <= 1'b0;
      frm  <= '0;
    end else if (tick) begin
      hcnt <= hcnt + 6'd1;
      if (hcnt == 6'd63) begin
        sub <= ~sub;
        if (sub) frm <= (frm == FRM_W'(FRAMES - 1)) ? '0 : frm + 1'b1;
      end
    end
  end

  // Pending holder and the pair in transmission.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_l    <= '0;
      pend_r    <= '0;
      cur_l     <= '0;
      cur_r     <= '0;
      vbit      <= 1'b1;
    end else begin
      if (accept) begin
        pend_l <= smp_left;
        pend_r <= smp_right;
      end
      if (frame_end) begin
        if (pend_full) begin
          cur_l <= fmt_field(pend_l, fmt24);
          cur_r <= fmt_field(pend_r, fmt24);
          vbit  <= 1'b0;
        end else begin
          vbit  <= 1'b1;
        end
      end
      pend_full <= accept ? 1'b1 : (frame_end ? 1'b0 : pend_full);
    end
  end
endmodule

// File: rtl/spdif_bmc.sv
module spdif_bmc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [5:0] hcnt,
  input  logic [7:0] pat,
  input  logic       data_bit,
  output logic       line
);
  logic base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line <= 1'b0;
      base <= 1'b0;
    end else if (tick) begin
      if (hcnt < 6'd8) begin
        if (hcnt == 6'd0) begin
          base <= line;
          line <= line ^ pat[7];
        end else begin
          line <= base ^ pat[3'd7 - hcnt[2:0]];
        end
      end else if (!hcnt[0]) begin
        line <= ~line;
      end else begin
        line <= line ^ data_bit;
      end
    end
  end
endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int FRAMES = 192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_ratio,
  input  logic              fmt24,
  input  logic [FRAMES-1:0] chan_stat,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [23:0]       smp_left,
  input  logic [23:0]       smp_right,
  output logic              spdif_out
);
  localparam int FRM_W = $clog2(FRAMES);

  logic             tick;
  logic [5:0]       hcnt;
  logic             sub;
  logic [FRM_W-1:0] frm;
  logic [23:0]      field;
  logic             vbit;
  logic             frame_end;
  logic             cbit;
  logic             data_bit;
  pre_kind_t        kind;
  logic [7:0]       pat;

  spdif_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .tick(tick)
  );

  spdif_framer #(.FRAMES(FRAMES)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt24(fmt24),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .smp_ready(smp_ready), .hcnt(hcnt), .sub(sub), .frm(frm),
    .field(field), .vbit(vbit), .frame_end(frame_end)
  );

  assign cbit     = chan_stat[frm];
  assign data_bit = slot_bit(field, vbit, cbit, hcnt[5:1]);
  assign kind     = sub ? PRE_RIGHT : ((frm == '0) ? PRE_BLOCK : PRE_LEFT);
  assign pat      = pre_pattern(kind);

  spdif_bmc u_bmc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hcnt(hcnt),
    .pat(pat), .data_bit(data_bit), .line(spdif_out)
  );
endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
  parameter int DIV_W  = 8,
  parameter int FRAMES = 192,
  localparam int FRM_W = $clog2(FRAMES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [DIV_W-1:0] div_ratio,
  input logic [5:0]       hcnt,
  input logic             sub,
  input logic [FRM_W-1:0] frm,
  input logic             spdif_out,
  input logic             smp_valid,
  input logic             smp_ready
);
  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_ratio != '0) |=> (!tick || div_ratio == '0));

  assert_quiet_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(spdif_out));

  assert_slot_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hcnt >= 6'd8 && !hcnt[0]) |=> (spdif_out != $past(spdif_out)));

  assert_pre_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hcnt == 6'd0) |=> (spdif_out != $past(spdif_out)));

  assert_frame_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frm < FRM_W'(FRAMES));

  assert_block_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hcnt == 6'd63 && sub && frm == FRM_W'(FRAMES - 1)) |=> (frm == '0));

  assert_one_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready);
endmodule

bind spdif_tx spdif_tx_chk #(.DIV_W(DIV_W), .FRAMES(FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .div_ratio(div_ratio),
  .hcnt(hcnt), .sub(sub), .frm(frm), .spdif_out(spdif_out),
  .smp_valid(smp_valid), .smp_ready(smp_ready)
);

// File: tb/sim_spdif_tx.sv
`timescale 1ns/1ps
module sim_spdif_tx;
  localparam int P     = 3;      // tick period in clocks (div_ratio + 1)
  localparam int NFRM  = 196;    // crosses one block wrap
  localparam int WDOG  = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   div_ratio = 8'(P - 1);
  logic         fmt24 = 1'b0;
  logic [191:0] chan_stat;
  logic         smp_valid = 1'b0;
  logic         smp_ready;
  logic [23:0]  smp_left = '0, smp_right = '0;
  logic         spdif_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spdif_tx u0 (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .fmt24(fmt24),
    .chan_stat(chan_stat), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_left(smp_left), .smp_right(smp_right), .spdif_out(spdif_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bench state
  logic        last_smp;
  int          unstable;
  bit          feed_wait;
  logic [23:0] cur_l, cur_r, nxt_l, nxt_r;
  bit          cur_v, nxt_have, cur_wide, nxt_wide;

  // Wait one tick period, sampling the line at every falling edge.
  task automatic grab(output logic b);
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      if (feed_wait) begin
        chk(smp_ready == 1'b0, "R8", "ready after accept", 32'(smp_ready), 32'd0);
        smp_valid = 1'b0;
        feed_wait = 0;
      end
      if (k < P - 1 && spdif_out !== last_smp) unstable++;
    end
    b = spdif_out;
    last_smp = b;
  endtask

  function automatic logic [23:0] mk_left(input int n);
    return 24'(n * 32'h1357B + 32'h0A5);
  endfunction
  function automatic logic [23:0] mk_right(input int n);
    return 24'(n * 32'h2468D) ^ 24'hF0F0F;
  endfunction

  initial begin
    logic [63:0] hv;
    logic        prev_lvl;
    int          lat;
    for (int i = 0; i < 192; i++) chan_stat[i] = (i % 5 == 0) || (i % 7 == 2);
    repeat (3) @(negedge clk);
    chk(spdif_out == 1'b0, "R10", "line in reset", 32'(spdif_out), 32'd0);
    chk(smp_ready == 1'b1, "R10", "ready in reset", 32'(smp_ready), 32'd1);
    rst_n = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (spdif_out == 1'b0);
    chk(lat == P, "R1", "first tick latency", 32'(lat), 32'(P));
    last_smp = spdif_out;
    prev_lvl = 1'b0;
    cur_l = '0; cur_r = '0; cur_v = 1; cur_wide = 1;
    nxt_have = 0; feed_wait = 0;

    for (int n = 0; n < NFRM; n++) begin
      for (int s = 0; s < 2; s++) begin
        logic [23:0] fld, expf;
        logic [7:0]  pre, exp_pre;
        logic        vb, ub, cb, pb;
        int          badedge;
        unstable = 0;
        for (int h = 0; h < 64; h++) begin
          logic b;
          if (n == 0 && s == 0 && h == 0) b = spdif_out;
          else grab(b);
          hv[h] = b;
          if (s == 0 && h == 0) begin
            // Frame n starts: its contents follow what was offered during frame n-1.
            if (nxt_have) begin
              cur_l = nxt_l; cur_r = nxt_r; cur_v = 0; cur_wide = nxt_wide;
            end else begin
              cur_v = 1;
            end
            nxt_have = 0;
            if ((n % 7) != 3 && n < NFRM - 1) begin
              chk(smp_ready == 1'b1, "R8", "ready at frame start", 32'(smp_ready), 32'd1);
              fmt24     = ((n + 1) >= 90 && (n + 1) < 150);
              smp_left  = mk_left(n + 1);
              smp_right = mk_right(n + 1);
              smp_valid = 1'b1;
              feed_wait = 1;
              nxt_have  = 1;
              nxt_wide  = fmt24;
              nxt_l     = fmt24 ? smp_left  : {smp_left[15:0], 8'h00};
              nxt_r     = fmt24 ? smp_right : {smp_right[15:0], 8'h00};
            end
          end
        end
        chk(unstable == 0, "R1", "line moved between ticks", 32'(unstable), 32'd0);
        // Preamble (R3, and R7 at the block wrap)
        for (int h = 0; h < 8; h++) pre[7 - h] = hv[h] ^ prev_lvl;
        exp_pre = (s == 1) ? 8'b1110_0100 : (((n % 192) == 0) ? 8'b1110_1000 : 8'b1110_0010);
        chk(pre == exp_pre, "R3", "preamble", 32'(pre), 32'(exp_pre));
        if (n == 192 && s == 0)
          chk(pre == 8'b1110_1000, "R7", "block restart", 32'(pre), 32'hE8);
        // Biphase-mark slot boundaries (R2)
        badedge = 0;
        for (int sl = 4; sl < 32; sl++)
          if (hv[2*sl] == hv[2*sl - 1]) badedge++;
        chk(badedge == 0, "R2", "missing slot-start toggle", 32'(badedge), 32'd0);
        // Decode slot bits
        for (int sl = 4; sl < 28; sl++) fld[sl - 4] = hv[2*sl] ^ hv[2*sl + 1];
        vb = hv[56] ^ hv[57];
        ub = hv[58] ^ hv[59];
        cb = hv[60] ^ hv[61];
        pb = hv[62] ^ hv[63];
        expf = s ? cur_r : cur_l;
        chk(fld == expf, "R4", "audio field", 32'(fld), 32'(expf));
        if (!cur_wide)
          chk(fld[7:0] == 8'h00, "R5", "16-bit mode low byte", 32'(fld[7:0]), 32'd0);
        chk(vb == cur_v, "R9", "validity", 32'(vb), 32'(cur_v));
        chk(ub == 1'b0, "R4", "user bit", 32'(ub), 32'd0);
        chk(cb == chan_stat[n % 192], "R6", "channel status", 32'(cb), 32'(chan_stat[n % 192]));
        chk(^{fld, vb, ub, cb, pb} == 1'b0, "R4", "parity", 32'(pb), 32'(^{fld, vb, ub, cb}));
        prev_lvl = hv[63];
      end
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule